// File: doc/BRIEF.md
# Consumer Clock Source Selector with Post-Divider

This block produces six consumer clocks from seven shared clock sources: one auxiliary PLL output and six frequency-generator outputs. A single 32-bit control word holds one 5-bit field for each consumer. The upper three bits of a field pick the source, with code zero meaning the consumer is turned off. The lower two bits pick a small post-divide ratio from a fixed lookup table. A parameter selects the extended variant of that table.

All logic runs on one fast reference clock. The source clocks are treated as slow waveforms that are synchronised and oversampled on that clock. Each consumer output is a register that moves only after a detected edge of its selected source. When software changes a field, the consumer keeps running its old setting until its output is low, and then takes the new setting in one step. The new source cannot cut short a high phase, and it cannot open a partial one.

The control word has a plain write strobe and is always visible on a read-back bus. There is no stream data path, so the block has no valid/ready interface and no back-pressure.

Top module: `csm_srcmux`

## Requirements
- R1: After reset the control word reads zero, every consumer clock is low and every consumer enable is low.
- R2: A write stores all 32 bits of `wr_data_i`, and `rd_data_o` shows exactly that value from the next cycle on.
- R3: Consumer i is controlled only by control-word bits [5i+4:5i] for i = 0..5. Bits [4:2] of a field are the source code and bits [1:0] are the divide code.
- R4: Source code 1 selects `aux_pll_i`. Source codes 2 to 7 select `fgen_i[0]` to `fgen_i[5]`.
- R5: Source code 0 turns the consumer off. Once that setting is applied, its clock stays low and its `cons_en_o` bit is low.
- R6: Divide code 0 reproduces the source shape: the output period and high time equal those of the source.
- R7: Divide code 1 divides by 4. The output is high for two source periods and low for two.
- R8: Divide code 3 divides by 2. The output is high for one source period and low for one.
- R9: With `EXT_DIV3` = 0, divide code 2 divides by 1, the same as code 0.
- R10: With `EXT_DIV3` = 1, divide code 2 divides by 3. The output is high for one source period and low for two.
- R11: A changed field takes effect only after the consumer output is low. Until then the old source and ratio keep running and `cons_en_o` keeps its old value. No high phase is shortened by a change.
- R12: A consumer output rises only after a rising edge of a source has been detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that samples the sources and clocks all state |
| rst_n | input | 1 | Active-low asynchronous reset |
| aux_pll_i | input | 1 | Auxiliary PLL clock, source code 1 |
| fgen_i | input | 6 | Frequency-generator clocks, source codes 2..7 |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Value to store into the control word |
| rd_data_o | output | 32 | Current control word |
| cons_clk_o | output | 6 | Consumer clocks |
| cons_en_o | output | 6 | Per-consumer flag: the applied source code is nonzero |

## Verification
The two functions that can collide are a control-word write and the falling edge of a running consumer output. A write that lands while the output is high must be held back, and the same rule decides whether the change is applied one cycle later or a whole high phase later. The bench waits until a slow divided output is high and then writes a disable, or a new source, in the middle of that phase. It checks that the output and its enable keep their old values until the natural falling edge, and that the enable changes one cycle after that edge. The bench then records every high phase across the switch and requires none of them to be shorter than the shorter of the two legal high times.

// File: rtl/csm_pkg.sv
package csm_pkg;

  localparam int FIELD_W = 5;
  localparam int SRC_W   = 3;
  localparam int DIVC_W  = 2;

  typedef struct packed {
    logic [SRC_W-1:0]  src;
    logic [DIVC_W-1:0] dcode;
  } cons_field_t;

  // Post-divide ratio for a 2-bit code; code 2 depends on the variant.
  function automatic logic [2:0] div_ratio(input logic [DIVC_W-1:0] code,
                                           input bit ext);
    case (code)
      2'd0:    div_ratio = 3'd1;
      2'd1:    div_ratio = 3'd4;
      2'd2:    div_ratio = ext ? 3'd3 : 3'd1;
      default: div_ratio = 3'd2;
    endcase
  endfunction

  // Number of source periods the divided output stays high.
  function automatic logic [2:0] high_span(input logic [2:0] ratio);
    case (ratio)
      3'd4:    high_span = 3'd2;
      default: high_span = 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/csm_ctrl_reg.sv
module csm_ctrl_reg #(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] word_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     word_q <= '0;
    else if (wr_en) word_q <= wr_data;
  end

endmodule

// File: rtl/csm_edge_det.sv
module csm_edge_det #(
  parameter int N           = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [N-1:0] stg [SYNC_STAGES];
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) stg[s] <= '0;
      prev_q <= '0;
    end else begin
      stg[0] <= lvl_i;
      for (int s = 1; s < SYNC_STAGES; s++) stg[s] <= stg[s-1];
      prev_q <= stg[LAST];
    end
  end

  assign rise_o = stg[LAST] & ~prev_q;
  assign fall_o = ~stg[LAST] & prev_q;

endmodule

// File: rtl/csm_channel.sv
module csm_channel
  import csm_pkg::*;
#(
  parameter int NUM_SRC  = 7,
  parameter bit EXT_DIV3 = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  cons_field_t        field_i,
  input  logic [NUM_SRC-1:0] rise_i,
  input  logic [NUM_SRC-1:0] fall_i,
  output logic               clk_o,
  output logic               en_o
);

  cons_field_t act_q;
  logic [1:0]  phase_q;
  logic        out_q;

  logic       sel_rise, sel_fall, pend, swap;
  logic [2:0] ratio, hspan;
  logic [1:0] nph;

  always_comb begin
    sel_rise = 1'b0;
    sel_fall = 1'b0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (act_q.src == SRC_W'(k + 1)) begin
        sel_rise = rise_i[k];
        sel_fall = fall_i[k];
      end
    end
  end

  assign ratio = div_ratio(act_q.dcode, EXT_DIV3);
  assign hspan = high_span(ratio);
  assign nph   = ({1'b0, phase_q} >= (ratio - 3'd1)) ? 2'd0 : phase_q + 2'd1;
  assign pend  = (act_q != field_i);
  assign swap  = pend && !out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= '0;
      phase_q <= 2'd3;
      out_q   <= 1'b0;
    end else if (swap) begin
      act_q   <= field_i;
      phase_q <= 2'd3;
      out_q   <= 1'b0;
    end else if (act_q.src == '0) begin
      out_q <= 1'b0;
    end else if (ratio == 3'd1) begin
      if (sel_rise)      out_q <= 1'b1;
      else if (sel_fall) out_q <= 1'b0;
    end else if (sel_rise) begin
      phase_q <= nph;
      out_q   <= ({1'b0, nph} < hspan);
    end
  end

  assign clk_o = out_q;
  assign en_o  = (act_q.src != '0);

endmodule

// File: rtl/csm_srcmux.sv
module csm_srcmux
  import csm_pkg::*;
#(
  parameter int NUM_CONS    = 6,
  parameter int REG_W       = 32,
  parameter int SYNC_STAGES = 2,
  parameter bit EXT_DIV3    = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                aux_pll_i,
  input  logic [NUM_CONS-1:0] fgen_i,
  input  logic                wr_en_i,
  input  logic [REG_W-1:0]    wr_data_i,
  output logic [REG_W-1:0]    rd_data_o,
  output logic [NUM_CONS-1:0] cons_clk_o,
  output logic [NUM_CONS-1:0] cons_en_o
);

  localparam int NUM_SRC = NUM_CONS + 1;

  logic [REG_W-1:0]   word_q;
  logic [NUM_SRC-1:0] src_lvl, src_rise, src_fall;

  assign src_lvl = {fgen_i, aux_pll_i};

  csm_ctrl_reg #(.REG_W(REG_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_data(wr_data_i),
    .word_q(word_q)
  );

  csm_edge_det #(.N(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(src_lvl),
    .rise_o(src_rise), .fall_o(src_fall)
  );

  for (genvar i = 0; i < NUM_CONS; i++) begin : g_cons
    csm_channel #(.NUM_SRC(NUM_SRC), .EXT_DIV3(EXT_DIV3)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .field_i(cons_field_t'(word_q[FIELD_W*i +: FIELD_W])),
      .rise_i(src_rise), .fall_i(src_fall),
      .clk_o(cons_clk_o[i]), .en_o(cons_en_o[i])
    );
  end

  assign rd_data_o = word_q;

endmodule

// File: rtl/csm_srcmux_chk.sv
module csm_srcmux_chk #(
  parameter int NUM_CONS = 6,
  parameter int REG_W    = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en_i,
  input logic [REG_W-1:0]    wr_data_i,
  input logic [REG_W-1:0]    rd_data_o,
  input logic [NUM_CONS-1:0] cons_clk_o,
  input logic [NUM_CONS-1:0] cons_en_o,
  input logic [NUM_CONS:0]   src_rise
);

  p_rd_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> rd_data_o == $past(wr_data_i));

  for (genvar i = 0; i < NUM_CONS; i++) begin : g_p
    p_off_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !cons_en_o[i] |-> !cons_clk_o[i]);
    p_en_on_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cons_en_o[i]) |-> !cons_clk_o[i]);
    p_en_off_after_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cons_en_o[i]) |-> $past(!cons_clk_o[i]));
    p_rise_aligned_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cons_clk_o[i]) |-> $past(|src_rise));
  end

endmodule

bind csm_srcmux csm_srcmux_chk #(.NUM_CONS(NUM_CONS), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
  .rd_data_o(rd_data_o), .cons_clk_o(cons_clk_o), .cons_en_o(cons_en_o),
  .src_rise(src_rise)
);

// File: tb/tb_csm_srcmux.sv
`timescale 1ns/1ps
module tb_csm_srcmux;

  localparam int PER [7] = '{6, 8, 10, 12, 14, 16, 18};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  srcs = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data, rd_data_x;
  logic [5:0]  clk_o, en_o, clk_x, en_x;
  int          cnt [7] = '{default: 0};
  int          n_chk = 0;
  int          n_fail = 0;

  always #5 clk = ~clk;

  always @(negedge clk) begin
    for (int k = 0; k < 7; k++) begin
      cnt[k]  <= (cnt[k] == PER[k] - 1) ? 0 : cnt[k] + 1;
      srcs[k] <= (cnt[k] < PER[k] / 2);
    end
  end

  csm_srcmux dut (
    .clk(clk), .rst_n(rst_n), .aux_pll_i(srcs[0]), .fgen_i(srcs[6:1]),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data),
    .cons_clk_o(clk_o), .cons_en_o(en_o)
  );

  csm_srcmux #(.EXT_DIV3(1'b1)) dut_x (
    .clk(clk), .rst_n(rst_n), .aux_pll_i(srcs[0]), .fgen_i(srcs[6:1]),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data_x),
    .cons_clk_o(clk_x), .cons_en_o(en_x)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic samp(input int ch, input bit x);
    return x ? clk_x[ch] : clk_o[ch];
  endfunction

  task automatic measure(input int ch, input bit x, output int per, output int hi);
    int g;
    g = 0; hi = 0; per = 0;
    while (samp(ch, x) == 1'b1 && g < 400) begin @(negedge clk); g++; end
    while (samp(ch, x) == 1'b0 && g < 400) begin @(negedge clk); g++; end
    while (samp(ch, x) == 1'b1 && g < 400) begin @(negedge clk); g++; hi++; end
    per = hi;
    while (samp(ch, x) == 1'b0 && g < 400) begin @(negedge clk); g++; per++; end
    if (g >= 400) per = -1;
  endtask

  task automatic steady(input int ch, input bit x, output int per, output int hi);
    measure(ch, x, per, hi);
    measure(ch, x, per, hi);
  endtask

  task automatic t_reset();
    chk(rd_data == 32'h0, "R1 word", rd_data, 0);
    chk(clk_o == 6'h0, "R1 clocks", clk_o, 0);
    chk(en_o == 6'h0, "R1 enables", en_o, 0);
  endtask

  task automatic t_readback();
    cfg(32'hA5C3_5A3C);
    chk(rd_data == 32'hA5C3_5A3C, "R2 pattern", rd_data, 32'hA5C3_5A3C);
    cfg(32'hFFFF_FFFF);
    chk(rd_data == 32'hFFFF_FFFF, "R2 ones", rd_data, 32'hFFFF_FFFF);
    cfg(32'h0);
  endtask

  task automatic t_sources();
    int p, h;
    for (int s = 1; s <= 7; s++) begin
      cfg(32'(s << 2));
      steady(0, 1'b0, p, h);
      chk(p == PER[s-1], "R4 source period", p, PER[s-1]);
      chk(h == PER[s-1] / 2, "R6 source high", h, PER[s-1] / 2);
    end
  endtask

  task automatic t_fields();
    int p, h;
    logic [31:0] v;
    v = '0;
    for (int i = 0; i < 6; i++) v |= 32'(((i + 2) << 2) << (5 * i));
    cfg(v);
    for (int i = 0; i < 6; i++) begin
      steady(i, 1'b0, p, h);
      chk(p == PER[i+1], "R3 field placement", p, PER[i+1]);
    end
    chk(en_o == 6'h3F, "R3 enables", en_o, 6'h3F);
  endtask

  task automatic t_disable();
    int highs;
    logic [31:0] v;
    v = '0;
    for (int i = 0; i < 6; i++) if (i != 4) v |= 32'(((i + 2) << 2) << (5 * i));
    cfg(v);
    repeat (40) @(negedge clk);
    highs = 0;
    for (int n = 0; n < 60; n++) begin
      @(negedge clk);
      if (clk_o[4]) highs++;
    end
    chk(highs == 0, "R5 disabled stays low", highs, 0);
    chk(en_o == 6'b101111, "R5 enable mask", en_o, 6'b101111);
  endtask

  task automatic t_div();
    int p, h;
    cfg(32'((4 | 1) << 10));
    steady(2, 1'b0, p, h);
    chk(p == 24 && h == 12, "R7 div4 period", p, 24);
    chk(h == 12, "R7 div4 high", h, 12);
    cfg(32'((4 | 3) << 10));
    steady(2, 1'b0, p, h);
    chk(p == 12 && h == 6, "R8 div2", p * 100 + h, 1206);
    cfg(32'((4 | 2) << 10));
    steady(2, 1'b0, p, h);
    chk(p == 6 && h == 3, "R9 code2 base", p * 100 + h, 603);
    steady(2, 1'b1, p, h);
    chk(p == 18, "R10 div3 period", p, 18);
    chk(h == 6, "R10 div3 high", h, 6);
  endtask

  task automatic t_switch();
    int g, p, h, run, min_hi;
    logic last;
    // consumer 1: fg5 (code 7), divide by 4 -> 36 cycles high
    cfg(32'(((7 << 2) | 1) << 5));
    steady(1, 1'b0, p, h);
    g = 0;
    while (!clk_o[1] && g < 400) begin @(negedge clk); g++; end
    repeat (3) @(negedge clk);
    cfg(32'h0);
    chk(clk_o[1] == 1'b1, "R11 old phase kept", clk_o[1], 1);
    chk(en_o[1] == 1'b1, "R11 enable held", en_o[1], 1);
    g = 0;
    while (clk_o[1] && g < 400) begin @(negedge clk); g++; end
    chk(en_o[1] == 1'b1, "R11 enable at fall", en_o[1], 1);
    @(negedge clk);
    chk(en_o[1] == 1'b0, "R11 enable after fall", en_o[1], 0);
    // aux /1 (high 3) to fg5 /2 (high 18); no high phase below 3
    cfg(32'((4 | 0) << 5));
    steady(1, 1'b0, p, h);
    cfg(32'(((7 << 2) | 3) << 5));
    min_hi = 1000; run = 0; last = clk_o[1];
    for (int n = 0; n < 200; n++) begin
      @(negedge clk);
      if (clk_o[1]) run++;
      else begin
        if (last && run > 0 && run < min_hi) min_hi = run;
        run = 0;
      end
      last = clk_o[1];
    end
    chk(min_hi >= 3, "R11 no runt high", min_hi, 3);
    steady(1, 1'b0, p, h);
    chk(p == 36 && h == 18, "R11 new setting", p * 100 + h, 3618);
  endtask

  initial begin
    #1_500_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_sources();
    t_fields();
    t_disable();
    t_div();
    t_switch();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule